// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Limiter

This block sits on one half-bridge output, between the PWM generator and the gate driver. When the current comparator reports an overcurrent, the half-bridge is driven to the opposite of its present level. That forced level is held until the next PWM frame begins. Short overloads therefore cost only the remainder of one frame, and the audio keeps going.

An up/down overload counter keeps a record of recent frames. Each frame that saw an overcurrent moves it up by one, and each clean frame moves it down by one. If the counter reaches full scale, the output is shut down into high impedance and stays there until reset. A mode input selects latched protection instead: in that mode the first overcurrent event shuts the output down at once. Each half-bridge gets its own instance.

Top module: `oc_limiter`

## Requirements
- R1: While `rst_n` is low and after it is released, `hiz_req` is 0, `limiting` is 0, the overload count is zero and `pwm_out` equals `pwm_in`.
- R2: With no overcurrent and no shutdown, `pwm_out` equals `pwm_in` in the same cycle, for both levels.
- R3: Once the overcurrent has passed the synchroniser, `limiting` goes to 1 and `pwm_out` holds the inverse of the `pwm_in` value seen at the event. It keeps that value while `pwm_in` changes.
- R4: A `frame_start` pulse with no overcurrent in the same cycle clears `limiting` at that clock edge. `pwm_out` follows `pwm_in` again from then on.
- R5: `oc_raw` passes two flops before it is used. A flag raised before clock edge k changes `limiting` at edge k+2, and not earlier.
- R6: At each `frame_start`, the count rises by one if the frame that just ended held at least one overcurrent. It never exceeds `CNT_MAX`.
- R7: At each `frame_start` after a clean frame, the count falls by one. It stays at zero rather than wrapping.
- R8: When the count reaches `CNT_MAX` (at a `frame_start` edge), `hiz_req` becomes 1 at that same edge and `pwm_out` is 0. Both persist, across frames and further overcurrent activity, until `rst_n` is asserted.
- R9: With `latch_mode` = 1, the first synchronised overcurrent sets `hiz_req` at the same edge where it would otherwise have set `limiting`.
- R10: An overcurrent that leaves the synchroniser in the same cycle as `frame_start` belongs to the new frame. `limiting` is set, not cleared, and is held through the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all state |
| frame_start | input | 1 | One-cycle pulse marking the first cycle of a PWM frame |
| pwm_in | input | 1 | Requested half-bridge level from the PWM generator |
| oc_raw | input | 1 | Asynchronous overcurrent comparator flag |
| latch_mode | input | 1 | 0 = cycle-by-cycle limiting, 1 = shut down on first event |
| pwm_out | output | 1 | Level passed to the gate driver (0 while shut down) |
| hiz_req | output | 1 | Request to put the half-bridge in high impedance |
| limiting | output | 1 | Status: the forced opposite level is active |

## Verification
Two events can land on the same clock edge: the release of the forced level at a frame boundary, and a fresh overcurrent leaving the synchroniser. The bench provokes this by raising `oc_raw` exactly two cycles before a `frame_start` pulse. It then judges that `limiting` is set at that edge and still holds after further cycles of the new frame. A second clash is a frame-boundary count update landing on the full-scale value. That case is judged by requiring `hiz_req` to appear in the cycle right after that boundary, in both the rising run and the run that starts after decrements.

// File: rtl/oc_limiter.sv
module oc_limiter #(
  parameter int CNT_MAX = 1020
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pwm_in,
  input  logic oc_raw,
  input  logic latch_mode,
  output logic pwm_out,
  output logic hiz_req,
  output logic limiting
);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic             oc_s1, oc_s2;
  logic             flip_q, forced_q, ev_q, hiz_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_s1 <= 1'b0;
      oc_s2 <= 1'b0;
    end else begin
      oc_s1 <= oc_raw;
      oc_s2 <= oc_s1;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (frame_start && !hiz_q) begin
      if (ev_q) begin
        if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign trip = !hiz_q && ((cnt_d == CNT_TOP) || (latch_mode && oc_s2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hiz_q <= 1'b0;
      ev_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hiz_q <= hiz_q | trip;
      if (hiz_q)            ev_q <= 1'b0;
      else if (frame_start) ev_q <= oc_s2;
      else if (oc_s2)       ev_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q   <= 1'b0;
      forced_q <= 1'b0;
    end else if (hiz_q || trip) begin
      flip_q <= 1'b0;
    end else if (oc_s2) begin
      if (!flip_q || frame_start) forced_q <= ~pwm_in;
      flip_q <= 1'b1;
    end else if (frame_start) begin
      flip_q <= 1'b0;
    end
  end

  assign pwm_out  = hiz_q ? 1'b0 : (flip_q ? forced_q : pwm_in);
  assign hiz_req  = hiz_q;
  assign limiting = flip_q;
endmodule

// File: rtl/oc_limiter_chk.sv
module oc_limiter_chk #(
  parameter int CNT_MAX = 1020,
  parameter int CNT_W   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             latch_mode,
  input logic             oc_s2,
  input logic [CNT_W-1:0] cnt_q,
  input logic             pwm_out,
  input logic             hiz_req,
  input logic             limiting
);
  // R8
  hiz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |=> hiz_req);

  // R8
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |-> (!pwm_out && !limiting));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !oc_s2) |=> !limiting);

  // R3
  forced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(limiting) && limiting && !$past(frame_start)) |-> (pwm_out == $past(pwm_out)));

  // R9
  latch_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && oc_s2) |=> hiz_req);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cnt_q));
endmodule

bind oc_limiter oc_limiter_chk #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .latch_mode(latch_mode),
  .oc_s2(oc_s2), .cnt_q(cnt_q), .pwm_out(pwm_out), .hiz_req(hiz_req),
  .limiting(limiting)
);

// File: tb/oc_limiter_tb.sv
module oc_limiter_tb;
  localparam int MAXC = 1020;
  localparam int FL   = 6;

  logic clk = 1'b0;
  logic rst_n, frame_start, pwm_in, oc_raw, latch_mode;
  logic pwm_out, hiz_req, limiting;
  int checks = 0, fails = 0;
  int m_cnt;
  bit m_prev, m_hiz;

  always #5 clk = ~clk;

  oc_limiter #(.CNT_MAX(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pwm_in(pwm_in),
    .oc_raw(oc_raw), .latch_mode(latch_mode), .pwm_out(pwm_out),
    .hiz_req(hiz_req), .limiting(limiting)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_start = 1'b0; oc_raw = 1'b0; latch_mode = 1'b0; pwm_in = 1'b0;
    m_cnt = 0; m_prev = 1'b0; m_hiz = 1'b0;
    step(); step();
    chk("R1 hiz in reset", hiz_req, 1'b0);
    chk("R1 limiting in reset", limiting, 1'b0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic run_frames(input int n, input bit with_oc);
    for (int i = 0; i < n; i++) begin
      frame_start = 1'b1; oc_raw = 1'b0;
      step();
      if (!m_hiz) begin
        if (m_prev) begin if (m_cnt < MAXC) m_cnt++; end
        else if (m_cnt > 0) m_cnt--;
        if (m_cnt == MAXC) m_hiz = 1'b1;
      end
      m_prev = with_oc;
      chk("R6 R7 R8 hiz per frame", hiz_req, m_hiz);
      if (m_hiz) chk("R8 output low in shutdown", pwm_out, 1'b0);
      frame_start = 1'b0; oc_raw = with_oc;
      step();
      oc_raw = 1'b0;
      repeat (FL - 2) step();
    end
  endtask

  task automatic t_reset_pass();
    do_reset();
    chk("R1 hiz after reset", hiz_req, 1'b0);
    chk("R1 limiting after reset", limiting, 1'b0);
    pwm_in = 1'b1; #1;
    chk("R2 pass high", pwm_out, 1'b1);
    pwm_in = 1'b0; #1;
    chk("R2 pass low", pwm_out, 1'b0);
  endtask

  task automatic t_flip_release();
    do_reset();
    pwm_in = 1'b0; oc_raw = 1'b1;
    step(); oc_raw = 1'b0;
    chk("R5 no effect after one edge", limiting, 1'b0);
    step();
    chk("R5 no effect after two edges", limiting, 1'b0);
    step();
    chk("R3 limiting set", limiting, 1'b1);
    chk("R3 forced opposite", pwm_out, 1'b1);
    pwm_in = 1'b1; step();
    chk("R3 held vs pwm_in high", pwm_out, 1'b1);
    pwm_in = 1'b0; step();
    chk("R3 held vs pwm_in low", pwm_out, 1'b1);
    frame_start = 1'b1; step(); frame_start = 1'b0;
    chk("R4 limiting cleared", limiting, 1'b0);
    chk("R4 follows pwm_in", pwm_out, 1'b0);
    pwm_in = 1'b1; #1;
    chk("R4 follows pwm_in high", pwm_out, 1'b1);
  endtask

  task automatic t_coincide();
    do_reset();
    pwm_in = 1'b1; oc_raw = 1'b1;
    step(); oc_raw = 1'b0;
    step(); frame_start = 1'b1;
    step(); frame_start = 1'b0;
    chk("R10 set at frame boundary", limiting, 1'b1);
    chk("R10 forced level", pwm_out, 1'b0);
    step(); step();
    chk("R10 held in new frame", limiting, 1'b1);
  endtask

  task automatic t_counter_up();
    do_reset();
    run_frames(MAXC + 1, 1'b1);
    chk("R8 shutdown reached", hiz_req, 1'b1);
    run_frames(3, 1'b0);
    chk("R8 stays after clean frames", hiz_req, 1'b1);
  endtask

  task automatic t_counter_updown();
    do_reset();
    run_frames(10, 1'b1);
    run_frames(4, 1'b0);
    run_frames(MAXC - 5, 1'b1);
    chk("R7 shutdown after decrements", hiz_req, 1'b1);
  endtask

  task automatic t_floor();
    do_reset();
    run_frames(5, 1'b0);
    run_frames(MAXC + 1, 1'b1);
    chk("R7 no underflow, shutdown at full scale", hiz_req, 1'b1);
  endtask

  task automatic t_latched();
    do_reset();
    latch_mode = 1'b1; pwm_in = 1'b1; oc_raw = 1'b1;
    step(); oc_raw = 1'b0;
    step();
    chk("R9 not yet", hiz_req, 1'b0);
    step();
    chk("R9 latched shutdown", hiz_req, 1'b1);
    chk("R9 output low", pwm_out, 1'b0);
    frame_start = 1'b1; step(); frame_start = 1'b0;
    chk("R8 held across frame", hiz_req, 1'b1);
    rst_n = 1'b0; step();
    chk("R1 reset clears shutdown", hiz_req, 1'b0);
    rst_n = 1'b1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; pwm_in = 1'b0; oc_raw = 1'b0; latch_mode = 1'b0;
    t_reset_pass();
    t_flip_release();
    t_coincide();
    t_counter_up();
    t_counter_updown();
    t_floor();
    t_latched();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule